// File: doc/BRIEF.md
# Maskable Time-Date Alarm Comparator

This block holds four alarm registers for seconds, minutes, hours and date. On every seconds tick it compares them with the live BCD time fields from the timekeeper. When every field that takes part in the comparison is equal, it sets a sticky alarm flag. The flag drives an interrupt request when the alarm interrupt is enabled.

Each alarm register uses its most significant bit as an exclude bit. Setting that bit takes the field out of the comparison, which sets how often the alarm repeats. The seconds field always takes part, so the fastest repeat rate is once per minute and the slowest is one second on one date.

Software writes the registers through a small write port. A write only lands while the global write-enable bit is high. The flag clears when software reads the flag register, which the host signals with a one-cycle strobe. The registers are volatile. After reset they hold date 00, which no live date ever equals, so the block stays quiet until software programs it.

Top module: `alarm_match`

## Requirements
- R1: After reset, alarm_flag and alarm_irq are 0. No alarm fires on any tick until software has written the registers, because the reset contents select date 00.
- R2: A write (wr_en=1) changes a register only when wen_bit=1. With wen_bit=0 the write is dropped and the registers keep their old contents.
- R3: For minutes, hours and date, bit 7 = 1 in the alarm register excludes that field from the comparison.
- R4: For a field with bit 7 = 0, bits 6:0 of the alarm register must equal bits 6:0 of the live field for a match.
- R5: The flag is set only on a cycle with sec_tick=1 and a full match. It becomes 1 on the following cycle.
- R6: A cycle with flag_rd=1 and no new match clears the flag on the following cycle. Otherwise the flag stays set.
- R7: When flag_rd=1 and a new match arrive in the same cycle, the flag is 1 on the next cycle.
- R8: alarm_irq is 1 exactly when alarm_flag is 1 and irq_en is 1.
- R9: The seconds field is always compared. Bit 7 of the seconds register is ignored. wr_sel selects the register: 0 seconds, 1 minutes, 2 hours, 3 date.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second from the timekeeper |
| cur_sec | input | 8 | Live seconds, BCD |
| cur_min | input | 8 | Live minutes, BCD |
| cur_hour | input | 8 | Live hours, BCD |
| cur_date | input | 8 | Live day of month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data; bit 7 is the exclude bit |
| wen_bit | input | 1 | Global write-enable bit |
| irq_en | input | 1 | Alarm interrupt enable |
| flag_rd | input | 1 | Flag register read strobe |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Interrupt request |

## Verification
The comparison is tried in four settings: all non-seconds fields excluded, one field unmasked with the live value one away from and then equal to the alarm value, all fields unmasked, and a seconds register with its exclude bit set. Together these separate a working mask from an ignored mask, and an exact compare from an off-by-one or partial compare. Matching time presented without a tick shows that the tick gates evaluation. Writes with the enable low show that the lock holds. A read that coincides with a match, and reads without a match, pin down the priority between set and clear. Toggling irq_en while the flag is set shows that the interrupt is masked and the flag is left alone.

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sec_tick,
  input  logic [W-1:0] cur_sec,
  input  logic [W-1:0] cur_min,
  input  logic [W-1:0] cur_hour,
  input  logic [W-1:0] cur_date,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         wen_bit,
  input  logic         irq_en,
  input  logic         flag_rd,
  output logic         alarm_flag,
  output logic         alarm_irq
);
  localparam int V = W - 1;

  logic [W-1:0] a_sec, a_min, a_hr, a_date;
  logic wr_ok, hit;

  assign wr_ok = wr_en & wen_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sec  <= '0;
      a_min  <= '0;
      a_hr   <= '0;
      a_date <= '0;
    end else if (wr_ok) begin
      case (wr_sel)
        2'd0: a_sec  <= wr_data;
        2'd1: a_min  <= wr_data;
        2'd2: a_hr   <= wr_data;
        default: a_date <= wr_data;
      endcase
    end
  end

  assign hit = sec_tick
             & (a_sec[V-1:0] == cur_sec[V-1:0])
             & (a_min[V]  | (a_min[V-1:0]  == cur_min[V-1:0]))
             & (a_hr[V]   | (a_hr[V-1:0]   == cur_hour[V-1:0]))
             & (a_date[V] | (a_date[V-1:0] == cur_date[V-1:0]));

  always_ff @(posedge clk) begin
    if (!rst_n)       alarm_flag <= 1'b0;
    else if (hit)     alarm_flag <= 1'b1;
    else if (flag_rd) alarm_flag <= 1'b0;
  end

  assign alarm_irq = alarm_flag & irq_en;
endmodule

module alarm_match_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sec_tick,
  input logic         wr_en,
  input logic         wen_bit,
  input logic         irq_en,
  input logic         flag_rd,
  input logic         alarm_flag,
  input logic         alarm_irq,
  input logic [4*W-1:0] regs
);
  assert_no_set_off_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !alarm_flag) |=> !alarm_flag);
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && flag_rd && !sec_tick) |=> !alarm_flag);
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !flag_rd) |=> alarm_flag);
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !alarm_irq);
  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> alarm_flag);
  assert_write_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wen_bit) |=> $stable(regs));
endmodule

bind alarm_match alarm_match_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
  .wen_bit(wen_bit), .irq_en(irq_en), .flag_rd(flag_rd),
  .alarm_flag(alarm_flag), .alarm_irq(alarm_irq),
  .regs({a_date, a_hr, a_min, a_sec})
);

// File: tb/test_alarm_match.sv
`timescale 1ns/1ps
module test_alarm_match;
  logic clk = 0, rst_n = 0, sec_tick = 0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_date = 8'h01;
  logic wr_en = 0, wen_bit = 0, irq_en = 0, flag_rd = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic alarm_flag, alarm_irq;
  int n_run = 0, n_fail = 0;
  int am [4];
  bit m_flag = 0;
  bit done = 0;

  always #4 clk = ~clk;

  alarm_match i_alarm_match (.*);

  function automatic bit model_hit();
    bit ok;
    int live [4];
    live[0] = cur_sec; live[1] = cur_min; live[2] = cur_hour; live[3] = cur_date;
    ok = sec_tick;
    for (int f = 0; f < 4; f++)
      if (f == 0 || am[f] < 128)
        if ((am[f] % 128) != (live[f] % 128)) ok = 0;
    return ok;
  endfunction

  always @(posedge clk) begin
    bit nf;
    if (!rst_n) begin
      for (int f = 0; f < 4; f++) am[f] = 0;
      nf = 0;
    end else begin
      nf = model_hit() ? 1'b1 : (flag_rd ? 1'b0 : m_flag);
      if (wr_en && wen_bit) am[wr_sel] = wr_data;
    end
    #1;
    m_flag = nf;
    if (rst_n && !done) begin
      n_run++;
      if (alarm_flag !== m_flag || alarm_irq !== (m_flag & irq_en)) begin
        n_fail++;
        $display("FAIL R5 R6 R7 R8 model: flag=%b irq=%b expected flag=%b irq=%b",
                 alarm_flag, alarm_irq, m_flag, m_flag & irq_en);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic tick(input logic [7:0] s, m, h, d, input logic rd = 0);
    @(negedge clk);
    cur_sec = s; cur_min = m; cur_hour = h; cur_date = d;
    sec_tick = 1; flag_rd = rd;
    @(negedge clk); sec_tick = 0; flag_rd = 0;
  endtask

  task automatic rd_flag();
    @(negedge clk); flag_rd = 1;
    @(negedge clk); flag_rd = 0;
  endtask

  initial begin
    #(200000 * 8);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flag after reset", alarm_flag, 0);
    chk("R1 irq after reset", alarm_irq, 0);
    tick(8'h00, 8'h00, 8'h00, 8'h01);
    chk("R1 unprogrammed no alarm", alarm_flag, 0);

    wen_bit = 0;
    wreg(0, 8'h05); wreg(1, 8'h80); wreg(2, 8'h80); wreg(3, 8'h80);
    tick(8'h05, 8'h12, 8'h03, 8'h01);
    chk("R2 locked write ignored", alarm_flag, 0);

    wen_bit = 1;
    wreg(0, 8'h10); wreg(1, 8'h80); wreg(2, 8'h80); wreg(3, 8'h80);
    wen_bit = 0;
    tick(8'h10, 8'h23, 8'h09, 8'h27);
    chk("R3 masked fields match", alarm_flag, 1);
    chk("R8 irq off when disabled", alarm_irq, 0);
    irq_en = 1; @(negedge clk);
    chk("R8 irq on when enabled", alarm_irq, 1);
    rd_flag();
    chk("R6 read clears flag", alarm_flag, 0);
    chk("R8 irq follows flag", alarm_irq, 0);

    @(negedge clk); cur_sec = 8'h10; @(negedge clk); @(negedge clk);
    chk("R5 no tick no flag", alarm_flag, 0);

    wen_bit = 1; wreg(1, 8'h45); wen_bit = 0;
    tick(8'h10, 8'h44, 8'h00, 8'h01);
    chk("R4 minutes differ", alarm_flag, 0);
    tick(8'h10, 8'h45, 8'h00, 8'h01);
    chk("R4 minutes equal", alarm_flag, 1);

    tick(8'h10, 8'h45, 8'h00, 8'h01, 1);
    chk("R7 read with match keeps flag", alarm_flag, 1);
    rd_flag();
    chk("R6 read clears after R7", alarm_flag, 0);

    wen_bit = 1; wreg(0, 8'h90); wen_bit = 0;
    tick(8'h11, 8'h45, 8'h00, 8'h01);
    chk("R9 seconds still compared", alarm_flag, 0);
    tick(8'h10, 8'h45, 8'h00, 8'h01);
    chk("R9 seconds match with bit7 set", alarm_flag, 1);
    rd_flag();

    wen_bit = 1; wreg(2, 8'h07); wreg(3, 8'h15); wen_bit = 0;
    tick(8'h10, 8'h45, 8'h07, 8'h16);
    chk("R4 date differs", alarm_flag, 0);
    tick(8'h10, 8'h45, 8'h06, 8'h15);
    chk("R4 hour differs", alarm_flag, 0);
    tick(8'h10, 8'h45, 8'h07, 8'h15);
    chk("R4 full match", alarm_flag, 1);
    chk("R8 irq on full match", alarm_irq, 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule